// File: doc/BRIEF.md
# Servo Channel Update Gate

This block sits beside a feedback servo and decides, for each output channel, whether the filter may write that channel's state in the current servo cycle. Each channel receives a small control word holding an output-switch enable, a filter-update enable and an active profile number. The switch enable drives the channel's RF switch at once. The profile number goes to the output stage through a two-stage pipeline clocked by the servo-cycle tick.

Each time a channel's switch turns on, or its profile number changes, an 8-bit hold count is reloaded. The count comes from the delay byte of the profile that is active at that moment. Filter updates stay blocked until the count has run down to zero, one step per servo tick. This lets an external amplifier settle before the loop starts to integrate. The profile memory and the filter arithmetic lie outside this block: the delay byte for the selected profile arrives on an input port, and the permit output is consumed by the filter.

Top module: `servo_chan_ctrl`

## Requirements
- R1: Control word fields are bit 0 = RF switch enable, bit 1 = filter-update enable, bits 6:2 = profile number (0-31). A word with only bit 1 set leaves both the switch and the permit low.
- R2: A write to a channel sets that channel's rf_sw_o to bit 0 of the word in the clock after the write, whether or not a tick occurs. Other channels' switches keep their value.
- R3: After a switch-on write, the channel's delay byte D is captured at the first tick that follows. permit_o goes high after the (D+1)th tick, so D = 0 permits after the first tick.
- R4: permit_o is high only when the switch and the update enable are both set. Clearing the update enable drops permit_o in the next clock without restarting the count, and setting it again restores permit_o at once.
- R5: A write that clears the switch drops permit_o in the next clock. The next switch-on needs a full new hold count.
- R6: A write that carries a different profile number restarts the hold count. Rewriting the same profile number does not.
- R7: A new profile number appears on prof_o after the second tick that comes strictly after the write, so the delay to the output stage is one to two servo cycles.
- R8: While reset is held, rf_sw_o, permit_o and prof_o are all zero.
- R9: A tick in the same clock as a restarting or switch-on write does not advance or load the hold count.
- R10: A change of the delay byte after it has been captured does not alter the count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we_i | input | NCH | Per-channel control-word write strobe |
| ctrl_data_i | input | 7 | Control word shared by all channels |
| cycle_tick_i | input | 1 | One-clock pulse per servo cycle |
| dly_i | input | NCH*8 | Delay byte of each channel's active profile |
| rf_sw_o | output | NCH | RF switch drive per channel |
| permit_o | output | NCH | Filter update allowed per channel |
| prof_o | output | NCH*5 | Profile number seen by the output stage |

## Verification
The hold count is tried with delays of zero, three and two, while the delay byte changes after capture; this separates an off-by-one in the load from a count that re-reads its source. Restart causes are applied one at a time: switch off, profile change, same-profile rewrite and update-enable toggle. This shows which of them must reload the count and which must leave it alone. Writes that land on the same clock as a tick check that the restart takes priority. Profile writes placed between ticks measure the two-tick pipeline to the output stage, and writes to one channel are checked for any effect on the other.

// File: rtl/scc_pkg.sv
// Package: shared widths and the control-word layout for the servo
// channel update gate. The struct is packed so that bit 0 is the switch
// enable, bit 1 the update enable and the upper bits the profile.
package scc_pkg;

    localparam int PROF_W = 5;
    localparam int DLY_W  = 8;

    typedef struct packed {
        logic [PROF_W-1:0] prof;
        logic              iir_en;
        logic              sw_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/chan_ctrl_reg.sv
// Module: holds one channel's control word. It flags a restart when a
// write clears the switch or carries a profile other than the current one.
// Assumes at most one write per clock per channel.
module chan_ctrl_reg
    import scc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  ctrl_t wdata,
    output ctrl_t cur,
    output logic  restart
);

    // Restart request, seen in the write cycle itself.
    always_comb begin
        restart = we && (!wdata.sw_en || (wdata.prof != cur.prof));
    end

    // Capture the control word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (we) begin
            cur <= wdata;
        end
    end

endmodule

// File: rtl/chan_hold_timer.sv
// Module: update-suppression counter for one channel. A reload is pending
// while the switch is off or after a restart. The first tick with the
// switch on captures the delay byte, and later ticks count down. Permit
// needs no pending reload, a zero count and both enables.
module chan_hold_timer
    import scc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             sw_on,
    input  logic             iir_en,
    input  logic             tick,
    input  logic [DLY_W-1:0] dly,
    output logic             permit
);

    logic             pend_q;
    logic [DLY_W-1:0] cnt_q;

    // Reload or count down the hold timer; a restart has priority over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b1;
            cnt_q  <= '0;
        end else if (restart || !sw_on) begin
            pend_q <= 1'b1;
            cnt_q  <= '0;
        end else if (tick) begin
            if (pend_q) begin
                pend_q <= 1'b0;
                cnt_q  <= dly;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Permit the filter update.
    always_comb begin
        permit = sw_on && iir_en && !pend_q && (cnt_q == '0);
    end

endmodule

// File: rtl/chan_prof_pipe.sv
// Module: carries the profile number to the output stage through two
// registers that load on the servo tick. A profile written between ticks
// therefore arrives one to two servo cycles later.
module chan_prof_pipe
    import scc_pkg::*;
#(
    parameter int STAGES = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [PROF_W-1:0] prof_in,
    output logic [PROF_W-1:0] prof_out
);

    logic [PROF_W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift one stage on each tick.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (tick) begin
                stage_q[s] <= (s == 0) ? prof_in : stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign prof_out = stage_q[STAGES-1];

endmodule

// File: rtl/chan_unit.sv
// Module: one complete channel, made of the control register, the hold
// timer and the profile pipeline. The switch output comes straight from
// the control register.
module chan_unit
    import scc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  ctrl_t             wdata,
    input  logic              tick,
    input  logic [DLY_W-1:0]  dly,
    output logic              rf_sw,
    output logic              permit,
    output logic [PROF_W-1:0] prof
);

    ctrl_t cur;
    logic  restart;

    chan_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .wdata   (wdata),
        .cur     (cur),
        .restart (restart)
    );

    chan_hold_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .sw_on   (cur.sw_en),
        .iir_en  (cur.iir_en),
        .tick    (tick),
        .dly     (dly),
        .permit  (permit)
    );

    chan_prof_pipe #(.STAGES(2)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .prof_in  (cur.prof),
        .prof_out (prof)
    );

    assign rf_sw = cur.sw_en;

endmodule

// File: rtl/servo_chan_ctrl.sv
// Module: top of the servo channel update gate. It holds NCH independent
// channels that share the control-word bus and the servo tick. Assumes
// the tick is a single-clock pulse and that dly_i carries the delay byte
// of each channel's currently selected profile.
module servo_chan_ctrl
    import scc_pkg::*;
#(
    parameter int NCH = 2
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        ctrl_we_i,
    input  logic [CTRL_W-1:0]     ctrl_data_i,
    input  logic                  cycle_tick_i,
    input  logic [NCH*DLY_W-1:0]  dly_i,
    output logic [NCH-1:0]        rf_sw_o,
    output logic [NCH-1:0]        permit_o,
    output logic [NCH*PROF_W-1:0] prof_o
);

    ctrl_t wdata;
    assign wdata = ctrl_t'(ctrl_data_i);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        chan_unit u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (ctrl_we_i[c]),
            .wdata  (wdata),
            .tick   (cycle_tick_i),
            .dly    (dly_i[c*DLY_W +: DLY_W]),
            .rf_sw  (rf_sw_o[c]),
            .permit (permit_o[c]),
            .prof   (prof_o[c*PROF_W +: PROF_W])
        );
    end

endmodule

// File: rtl/servo_chan_ctrl_chk.sv
// Module: checker for servo_chan_ctrl, attached by bind. It observes
// ports only.
module servo_chan_ctrl_chk
    import scc_pkg::*;
#(
    parameter int NCH = 2
)(
    input logic                  clk,
    input logic                  rst_n,
    input logic [NCH-1:0]        ctrl_we_i,
    input logic [CTRL_W-1:0]     ctrl_data_i,
    input logic                  cycle_tick_i,
    input logic [NCH*DLY_W-1:0]  dly_i,
    input logic [NCH-1:0]        rf_sw_o,
    input logic [NCH-1:0]        permit_o,
    input logic [NCH*PROF_W-1:0] prof_o
);

    // R8: outputs are clear in the clock after a reset cycle.
    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (rf_sw_o == '0 && permit_o == '0 && prof_o == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R2: the switch takes bit 0 of the written word.
        p_rf_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_we_i[c] |=> rf_sw_o[c] == $past(ctrl_data_i[0]));

        // R2: without a write, the switch keeps its value.
        p_rf_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_we_i[c] |=> $stable(rf_sw_o[c]));

        // R4: permit needs the switch on.
        p_permit_sw_r4: assert property (@(posedge clk) disable iff (!rst_n)
            permit_o[c] |-> rf_sw_o[c]);

        // R5: a switch-off write removes the permit.
        p_off_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_we_i[c] && !ctrl_data_i[0]) |=> !permit_o[c]);

        // R7: the output-stage profile moves only on a tick.
        p_prof_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !cycle_tick_i |=> $stable(prof_o[c*PROF_W +: PROF_W]));
    end

endmodule

bind servo_chan_ctrl servo_chan_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_data_i  (ctrl_data_i),
    .cycle_tick_i (cycle_tick_i),
    .dly_i        (dly_i),
    .rf_sw_o      (rf_sw_o),
    .permit_o     (permit_o),
    .prof_o       (prof_o)
);

// File: tb/servo_chan_ctrl_test.sv
`timescale 1ns/1ps
module servo_chan_ctrl_test;
    import scc_pkg::*;

    localparam int NCH = 2;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NCH-1:0]        ctrl_we_i = '0;
    logic [CTRL_W-1:0]     ctrl_data_i = '0;
    logic                  cycle_tick_i = 1'b0;
    logic [NCH*DLY_W-1:0]  dly_i = '0;
    logic [NCH-1:0]        rf_sw_o;
    logic [NCH-1:0]        permit_o;
    logic [NCH*PROF_W-1:0] prof_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    servo_chan_ctrl #(.NCH(NCH)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we_i    (ctrl_we_i),
        .ctrl_data_i  (ctrl_data_i),
        .cycle_tick_i (cycle_tick_i),
        .dly_i        (dly_i),
        .rf_sw_o      (rf_sw_o),
        .permit_o     (permit_o),
        .prof_o       (prof_o)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [CTRL_W-1:0] word(input bit sw, input bit iir, input int prof);
        return {prof[PROF_W-1:0], iir, sw};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ctrl_we_i = '0;
        cycle_tick_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int ch, input logic [CTRL_W-1:0] d);
        @(negedge clk);
        ctrl_we_i[ch] = 1'b1;
        ctrl_data_i = d;
        @(negedge clk);
        ctrl_we_i = '0;
    endtask

    task automatic tk();
        @(negedge clk);
        cycle_tick_i = 1'b1;
        @(negedge clk);
        cycle_tick_i = 1'b0;
    endtask

    task automatic wr_tk(input int ch, input logic [CTRL_W-1:0] d);
        @(negedge clk);
        ctrl_we_i[ch] = 1'b1;
        ctrl_data_i = d;
        cycle_tick_i = 1'b1;
        @(negedge clk);
        ctrl_we_i = '0;
        cycle_tick_i = 1'b0;
    endtask

    // R8: outputs cleared while reset is held.
    task automatic t_reset();
        do_reset();
        dly_i[7:0] = 8'd0;
        wr(0, word(1, 1, 9));
        tk(); tk();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 rf_sw", rf_sw_o, 0);
        chk("R8 permit", permit_o, 0);
        chk("R8 prof", prof_o, 0);
        rst_n = 1'b1;
    endtask

    // R1: field positions of the control word.
    task automatic t_fields();
        do_reset();
        dly_i[15:8] = 8'd0;
        wr(1, 7'b0000010);
        chk("R1 iir-only rf", rf_sw_o[1], 0);
        tk();
        chk("R1 iir-only permit", permit_o[1], 0);
        wr(1, 7'b1111101);
        chk("R1 sw bit0", rf_sw_o[1], 1);
        tk(); tk();
        chk("R1 prof bits6:2", prof_o[9:5], 31);
        chk("R1 iir bit1 clear", permit_o[1], 0);
    endtask

    // R2: switch follows the write at once and per channel.
    task automatic t_rf();
        do_reset();
        wr(0, word(1, 0, 0));
        chk("R2 ch0 on", rf_sw_o[0], 1);
        chk("R2 ch1 untouched", rf_sw_o[1], 0);
        wr(1, word(1, 0, 0));
        chk("R2 ch1 on", rf_sw_o[1], 1);
        wr(0, word(0, 0, 0));
        chk("R2 ch0 off", rf_sw_o[0], 0);
        chk("R2 ch1 kept", rf_sw_o[1], 1);
    endtask

    // R3: permit after D+1 ticks.
    task automatic t_delay(input int d);
        do_reset();
        dly_i[7:0] = d[7:0];
        wr(0, word(1, 1, 3));
        chk("R3 before tick", permit_o[0], 0);
        for (int i = 0; i < d; i++) begin
            tk();
            chk("R3 counting", permit_o[0], 0);
        end
        tk();
        chk("R3 released", permit_o[0], 1);
    endtask

    // R10: delay byte captured once.
    task automatic t_dly_latched();
        do_reset();
        dly_i[7:0] = 8'd2;
        wr(0, word(1, 1, 1));
        tk();
        dly_i[7:0] = 8'd200;
        tk();
        chk("R10 mid count", permit_o[0], 0);
        tk();
        chk("R10 captured value used", permit_o[0], 1);
    endtask

    // R4 and R5: update enable gating and switch-off restart.
    task automatic t_gate_and_off();
        do_reset();
        dly_i[7:0] = 8'd0;
        wr(0, word(1, 1, 1));
        tk();
        chk("R4 permit on", permit_o[0], 1);
        wr(0, word(1, 0, 1));
        chk("R4 iir cleared", permit_o[0], 0);
        wr(0, word(1, 1, 1));
        chk("R4 iir restored no tick", permit_o[0], 1);
        wr(0, word(0, 1, 1));
        chk("R5 off drops permit", permit_o[0], 0);
        wr(0, word(1, 1, 1));
        chk("R5 on needs tick", permit_o[0], 0);
        tk();
        chk("R5 new count done", permit_o[0], 1);
    endtask

    // R6: profile change restarts, same profile does not.
    task automatic t_prof_restart();
        do_reset();
        dly_i[7:0] = 8'd1;
        wr(0, word(1, 1, 4));
        tk(); tk();
        chk("R6 initial permit", permit_o[0], 1);
        wr(0, word(1, 1, 4));
        chk("R6 same profile keeps", permit_o[0], 1);
        wr(0, word(1, 1, 9));
        chk("R6 new profile blocks", permit_o[0], 0);
        tk();
        chk("R6 reloaded", permit_o[0], 0);
        tk();
        chk("R6 released", permit_o[0], 1);
    endtask

    // R7: two-tick profile latency.
    task automatic t_prof_latency();
        do_reset();
        wr(0, word(1, 0, 7));
        chk("R7 no tick", prof_o[4:0], 0);
        tk();
        chk("R7 one tick", prof_o[4:0], 0);
        tk();
        chk("R7 two ticks", prof_o[4:0], 7);
        chk("R7 ch1 unchanged", prof_o[9:5], 0);
    endtask

    // R9: tick coinciding with restart or switch-on is ignored by the timer.
    task automatic t_collision();
        do_reset();
        dly_i[7:0] = 8'd0;
        wr(0, word(1, 1, 2));
        tk();
        chk("R9 setup", permit_o[0], 1);
        wr_tk(0, word(1, 1, 6));
        chk("R9 restart wins", permit_o[0], 0);
        tk();
        chk("R9 after next tick", permit_o[0], 1);
        do_reset();
        wr_tk(0, word(1, 1, 0));
        chk("R9 switch-on with tick", permit_o[0], 0);
        tk();
        chk("R9 switch-on then tick", permit_o[0], 1);
    endtask

    initial begin
        do_reset();
        chk("R8 initial rf_sw", rf_sw_o, 0);
        chk("R8 initial permit", permit_o, 0);
        chk("R8 initial prof", prof_o, 0);
        t_reset();
        t_fields();
        t_rf();
        t_delay(3);
        t_delay(0);
        t_dly_latched();
        t_gate_and_off();
        t_prof_restart();
        t_prof_latency();
        t_collision();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule